// File: doc/BRIEF.md
# Timer Main Counter with Modulo and Up/Down Counting

This block is the central count register of a timer/PWM unit. It runs entirely in the bus clock domain and advances on one-cycle count-enable pulses. A two-bit select picks where those pulses come from:

- every bus cycle;
- the rising edges of a fixed-frequency clock;
- the rising edges of an external clock.

Each of the two slower sources is first re-timed into the bus domain, then edge-detected.

In edge-aligned operation the counter climbs from zero and wraps to zero. It wraps either at its all-ones value or at a programmed modulus. In center-aligned operation it rises to the modulus and falls back to zero, again and again. A direction output follows which way it is counting. An overflow flag marks the end of each period and drives an interrupt line when enabled. Software clears the flag with a strobe.

Software reaches the block through a three-register write/read port: control, count and modulus. Channel compare and capture units elsewhere in the timer use the count and direction outputs.

Top module: `tmr_counter`

## Requirements
- R1: After reset the following hold: clock select is 00, the count is 0x0000, the direction output is 0 (up), the overflow flag is 0, and the interrupt line is low.
- R2: With clock select 00 the count does not change. The modulus and flag also keep their values, read back through the read port.
- R3: Clock select 01 advances the count once per bus clock cycle.
- R4: Clock select 10 steps once per rising edge of `fix_clk_i`; clock select 11 steps once per rising edge of `ext_clk_i`. The source that is not selected has no effect. A rising edge driven just after a bus clock edge changes the count on the third following bus clock edge.
- R5: In up mode (control bit 2 = 0) with modulus 0x0000, the count runs from 0x0000 to 0xFFFF and then wraps to 0x0000. The flag is set on that wrap and not before.
- R6: In up mode with a nonzero modulus M, the count wraps from M to 0x0000 and the flag is set on that step.
- R7: In center mode (control bit 2 = 1) with modulus M ≥ 1:
  - the count rises to M, then falls to 0, then rises again;
  - the flag is set on the step from M to M−1;
  - `dir_down_o` is 1 while falling.
- R8: In center mode with modulus 0x0000 the count stays at 0x0000 and the flag is never set.
- R9: `irq_o` is high exactly while the flag is 1 and the interrupt enable (control bit 3) is 1.
- R10: A control write with bit 7 = 1 clears the flag. If an overflow occurs in the same cycle, the flag stays set.
- R11: Any write to the count register forces the count to 0x0000 and the direction to up. This applies in any mode.
- R12: Register map:
  - address 0 is control: bits[1:0] clock select, bit 2 center mode, bit 3 interrupt enable; on reads bit 7 returns the flag;
  - address 1 is the count;
  - address 2 is the modulus;
  - address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 16 | Read data (combinational) |
| fix_clk_i | input | 1 | Fixed-frequency clock source |
| ext_clk_i | input | 1 | External clock source |
| count_o | output | 16 | Counter value |
| dir_down_o | output | 1 | 1 while counting down |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The assertions assume the following about the inputs:
- `fix_clk_i` and `ext_clk_i` each stay high and low long enough for the synchronizer to see every level, so each edge yields exactly one isolated pulse;
- the modulus is not lowered under a running count in center mode.

The stimulus respects both. It holds each level of the slow clocks for two bus cycles, which is within the quarter-bus-rate limit. It changes the modulus only while the counter is stopped and the count has just been reset. All inputs change half a period away from the sampling edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_MOD   = 2'd2;

  localparam int unsigned BIT_CENTER = 2;
  localparam int unsigned BIT_IE     = 3;
  localparam int unsigned BIT_FLAG   = 7;

  typedef enum logic [1:0] {
    CS_OFF = 2'b00,
    CS_BUS = 2'b01,
    CS_FIX = 2'b10,
    CS_EXT = 2'b11
  } clk_sel_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign pulse_o = sync_q[STAGES-1] & ~last_q;

  // R4: one bus-cycle pulse per source edge
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/tmr_src_mux.sv
module tmr_src_mux
  import tmr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  clk_sel_e sel_i,
  input  logic     fix_clk_i,
  input  logic     ext_clk_i,
  output logic     tick_o
);
  localparam int unsigned N_SRC = 2;

  logic [N_SRC-1:0] src;
  logic [N_SRC-1:0] pulse;

  assign src = {ext_clk_i, fix_clk_i};

  for (genvar i = 0; i < N_SRC; i++) begin : g_sync
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (src[i]),
      .pulse_o (pulse[i])
    );
  end

  always_comb begin
    unique case (sel_i)
      CS_BUS:  tick_o = 1'b1;
      CS_FIX:  tick_o = pulse[0];
      CS_EXT:  tick_o = pulse[1];
      default: tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             center_i,
  input  logic [CNT_W-1:0] mod_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             down_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, top;
  logic             dn_q, dn_d;
  logic             no_mod;

  assign no_mod = (mod_i == '0);
  assign top    = no_mod ? {CNT_W{1'b1}} : mod_i;

  always_comb begin
    cnt_d = cnt_q;
    dn_d  = dn_q & center_i;
    ovf_o = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
      dn_d  = 1'b0;
    end else if (tick_i) begin
      if (!center_i) begin
        if (cnt_q >= top) begin
          cnt_d = '0;
          ovf_o = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (no_mod) begin
        cnt_d = '0;
        dn_d  = 1'b0;
      end else if (!dn_q) begin
        if (cnt_q >= mod_i) begin
          cnt_d = cnt_q - 1'b1;
          dn_d  = 1'b1;
          ovf_o = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (cnt_q == '0) begin
        cnt_d = cnt_q + 1'b1;
        dn_d  = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign down_o = dn_q;

  // R5 R6: wrap to zero at top of count
  a_r6_up_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !center_i && !clr_i && cnt_q == top) |=> (cnt_q == '0 && !dn_q));

  // R7: turn at modulus
  a_r7_center_turn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && center_i && !clr_i && !no_mod && !dn_q && cnt_q == mod_i)
      |=> (dn_q && cnt_q == CNT_W'($past(mod_i) - 1'b1)));

  // R8: center mode with no modulus holds zero
  a_r8_hold_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && center_i && no_mod && !clr_i) |=> (cnt_q == '0));

  // R11: count write restarts upward from zero
  a_r11_count_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !dn_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  input  logic              fix_clk_i,
  input  logic              ext_clk_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              dir_down_o,
  output logic              irq_o
);
  clk_sel_e         sel_q;
  logic             center_q, ie_q, flag_q;
  logic [CNT_W-1:0] mod_q;
  logic             ctrl_wr, cnt_wr, mod_wr, flag_clr;
  logic             tick, ovf;

  assign ctrl_wr  = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign cnt_wr   = wr_en_i && (wr_addr_i == ADDR_COUNT);
  assign mod_wr   = wr_en_i && (wr_addr_i == ADDR_MOD);
  assign flag_clr = ctrl_wr && wr_data_i[BIT_FLAG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= CS_OFF;
      center_q <= 1'b0;
      ie_q     <= 1'b0;
      mod_q    <= '0;
    end else begin
      if (ctrl_wr) begin
        sel_q    <= clk_sel_e'(wr_data_i[1:0]);
        center_q <= wr_data_i[BIT_CENTER];
        ie_q     <= wr_data_i[BIT_IE];
      end
      if (mod_wr) mod_q <= wr_data_i;
    end
  end

  // overflow set has priority over the software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (ovf)      flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  tmr_src_mux #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel_q),
    .fix_clk_i (fix_clk_i),
    .ext_clk_i (ext_clk_i),
    .tick_o    (tick)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .center_i (center_q),
    .mod_i    (mod_q),
    .clr_i    (cnt_wr),
    .cnt_o    (count_o),
    .down_o   (dir_down_o),
    .ovf_o    (ovf)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      ADDR_CTRL: begin
        rd_data_o[1:0]        = sel_q;
        rd_data_o[BIT_CENTER] = center_q;
        rd_data_o[BIT_IE]     = ie_q;
        rd_data_o[BIT_FLAG]   = flag_q;
      end
      ADDR_COUNT: rd_data_o = count_o;
      ADDR_MOD:   rd_data_o = mod_q;
      default:    rd_data_o = '0;
    endcase
  end

  assign irq_o = flag_q & ie_q;

  // R2: stopped counter holds
  a_r2_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == CS_OFF && !cnt_wr) |=> $stable(count_o));

  // R10: set wins over clear
  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> flag_q);
endmodule

// File: tb/tb_tmr_counter.sv
module tb_tmr_counter;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [1:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic        fix_clk_i = 1'b0;
  logic        ext_clk_i = 1'b0;
  logic [15:0] count_o;
  logic        dir_down_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tmr_counter dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .fix_clk_i(fix_clk_i), .ext_clk_i(ext_clk_i), .count_o(count_o),
    .dir_down_o(dir_down_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic        ctr;
    logic [15:0] md;
    logic [7:0]  n;
    logic [15:0] cnt;
    logic        dn;
    logic        fl;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 1'b0, 16'd0, 8'd5,  16'd5, 1'b0, 1'b0},  // R3 R5
    '{2'b01, 1'b0, 16'd4, 8'd5,  16'd0, 1'b0, 1'b1},  // R6
    '{2'b01, 1'b0, 16'd4, 8'd7,  16'd2, 1'b0, 1'b1},  // R6
    '{2'b01, 1'b1, 16'd3, 8'd3,  16'd3, 1'b0, 1'b0},  // R7
    '{2'b01, 1'b1, 16'd3, 8'd4,  16'd2, 1'b1, 1'b1},  // R7
    '{2'b01, 1'b1, 16'd3, 8'd6,  16'd0, 1'b1, 1'b1},  // R7
    '{2'b01, 1'b1, 16'd3, 8'd7,  16'd1, 1'b0, 1'b1},  // R7
    '{2'b01, 1'b1, 16'd0, 8'd10, 16'd0, 1'b0, 1'b0},  // R8
    '{2'b01, 1'b0, 16'd1, 8'd3,  16'd1, 1'b0, 1'b1},  // R6
    '{2'b01, 1'b1, 16'd1, 8'd2,  16'd0, 1'b1, 1'b1}   // R7
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  function automatic logic [15:0] ctrl(logic [1:0] sel, logic ctr, logic ie, logic clr);
    return {8'h00, clr, 3'b000, ie, ctr, sel};
  endfunction

  function automatic logic flag_rd();
    return rd_data_o[7];
  endfunction

  task automatic setup(logic ctr, logic ie, logic [15:0] md);
    wr(2'd0, ctrl(2'b00, ctr, ie, 1'b1));
    wr(2'd2, md);
    wr(2'd1, 16'h0);
  endtask

  task automatic pulse_src(bit fix, bit ext, int n);
    for (int i = 0; i < n; i++) begin
      if (fix) fix_clk_i = 1'b1;
      if (ext) ext_clk_i = 1'b1;
      repeat (2) @(negedge clk_i);
      fix_clk_i = 1'b0; ext_clk_i = 1'b0;
      repeat (2) @(negedge clk_i);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] snap;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state; R12 control readback
    rd_addr_i = 2'd0;
    check("R1 count", count_o, 16'h0);
    check("R1 dir", dir_down_o, 1'b0);
    check("R1 irq", irq_o, 1'b0);
    check("R1 ctrl", rd_data_o, 16'h0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      setup(VECS[v].ctr, 1'b1, VECS[v].md);
      wr(2'd0, ctrl(VECS[v].sel, VECS[v].ctr, 1'b1, 1'b0));
      repeat (int'(VECS[v].n)) @(negedge clk_i);
      check($sformatf("R5-7 vec%0d count", v), count_o, VECS[v].cnt);
      check($sformatf("R7 vec%0d dir", v), dir_down_o, VECS[v].dn);
      check($sformatf("R6 vec%0d flag", v), flag_rd(), VECS[v].fl);
    end

    // R5 free-running full range
    setup(1'b0, 1'b0, 16'h0);
    wr(2'd0, ctrl(2'b01, 1'b0, 1'b0, 1'b0));
    repeat (65535) @(negedge clk_i);
    check("R5 at FFFF", count_o, 16'hFFFF);
    check("R5 no flag yet", flag_rd(), 1'b0);
    @(negedge clk_i);
    check("R5 wrap", count_o, 16'h0);
    check("R5 flag", flag_rd(), 1'b1);

    // R2 stop holds count and registers
    setup(1'b0, 1'b0, 16'd9);
    wr(2'd0, ctrl(2'b01, 1'b0, 1'b0, 1'b0));
    repeat (4) @(negedge clk_i);
    wr(2'd0, ctrl(2'b00, 1'b0, 1'b0, 1'b0));
    snap = count_o;
    repeat (10) @(negedge clk_i);
    check("R2 count held", count_o, snap);
    check("R2 flag held", flag_rd(), 1'b0);
    rd_addr_i = 2'd2;
    @(negedge clk_i);
    check("R2 R12 mod readback", rd_data_o, 16'd9);
    rd_addr_i = 2'd1;
    @(negedge clk_i);
    check("R12 count readback", rd_data_o, snap);
    rd_addr_i = 2'd3;
    @(negedge clk_i);
    check("R12 addr3", rd_data_o, 16'h0);
    rd_addr_i = 2'd0;

    // R4 fixed clock, latency, and unselected ext ignored
    setup(1'b0, 1'b0, 16'h0);
    wr(2'd0, ctrl(2'b10, 1'b0, 1'b0, 1'b0));
    fix_clk_i = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R4 latency before", count_o, 16'd0);
    fix_clk_i = 1'b0;
    @(negedge clk_i);
    check("R4 latency step", count_o, 16'd1);
    @(negedge clk_i);
    pulse_src(1'b1, 1'b1, 3);
    pulse_src(1'b0, 1'b1, 2);
    repeat (4) @(negedge clk_i);
    check("R4 fixed edges", count_o, 16'd4);

    // R4 external clock
    setup(1'b0, 1'b0, 16'h0);
    wr(2'd0, ctrl(2'b11, 1'b0, 1'b0, 1'b0));
    pulse_src(1'b0, 1'b1, 5);
    pulse_src(1'b1, 1'b0, 2);
    repeat (4) @(negedge clk_i);
    check("R4 ext edges", count_o, 16'd5);

    // R9 interrupt gating, R10 clear and set-wins
    setup(1'b0, 1'b0, 16'd1);
    wr(2'd0, ctrl(2'b01, 1'b0, 1'b0, 1'b0));
    repeat (3) @(negedge clk_i);
    check("R9 flag set", flag_rd(), 1'b1);
    check("R9 irq masked", irq_o, 1'b0);
    wr(2'd0, ctrl(2'b01, 1'b0, 1'b1, 1'b0));
    check("R9 irq enabled", irq_o, 1'b1);
    while (count_o != 16'd1) @(negedge clk_i);
    wr(2'd0, ctrl(2'b01, 1'b0, 1'b1, 1'b1));
    check("R10 set wins", flag_rd(), 1'b1);
    check("R10 irq kept", irq_o, 1'b1);
    wr(2'd0, ctrl(2'b01, 1'b0, 1'b1, 1'b1));
    check("R10 cleared", flag_rd(), 1'b0);
    check("R10 R9 irq low", irq_o, 1'b0);

    // R11 count write in center mode while falling
    setup(1'b1, 1'b0, 16'd5);
    wr(2'd0, ctrl(2'b01, 1'b1, 1'b0, 1'b0));
    repeat (7) @(negedge clk_i);
    check("R11 pre count", count_o, 16'd3);
    check("R11 pre dir", dir_down_o, 1'b1);
    wr(2'd1, 16'hABCD);
    check("R11 count zero", count_o, 16'd0);
    check("R11 dir up", dir_down_o, 1'b0);
    @(negedge clk_i);
    check("R11 restart up", count_o, 16'd1);

    finish_run();
  end
endmodule